// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with APB Register Port

This block is a down-counting watchdog that sits on an APB slave port. Software programs a start value, turns the block on, and must then service it before the count runs out. The counter moves down by one only in cycles where the external tick-enable input is high, so the counting rate is set by whoever drives that input and may change at any moment without touching the count. When the count hits zero the block latches an interrupt. On the next tick it restarts from the programmed value instead of wrapping.

If the count runs out a second time while the first interrupt is still pending, the block can raise a sticky reset request. Software services the watchdog by writing anything to the interrupt-clear register. That write drops the interrupt and restarts the count in one access. A key-protected lock shields the control registers from stray writes. The port has zero wait states.

Top module: `apb_tick_watchdog`

## Requirements
- R1: After reset: the load register and the current value read 0xFFFFFFFF, raw status reads 0, control reads 0, the lock register reads 0 (unlocked), and both `irq` and `rst_req` are low.
- R2: Register byte offsets are load 0x000, current value 0x004, control 0x008, interrupt clear 0x00C, raw status 0x010 (bit 0), masked status 0x014 (bit 0) and lock 0xC00. Any other offset reads 0, and `pready` is always 1.
- R3: A load write sets the counter to the written value at once. After N enabled ticks the value register reads the load value minus N.
- R4: On the tick that brings the counter to 0, raw status becomes 1 and the value register reads 0.
- R5: On the next enabled tick the counter restarts from the load register. Raw status stays 1 until it is cleared.
- R6: A write of any data to the interrupt-clear offset clears raw status and reloads the counter from the load register in that same access.
- R7: Control bit 0 enables counting and the interrupt. Masked status and `irq` equal raw status AND control bit 0.
- R8: While control bit 0 is 0, ticks leave the count unchanged. Load and interrupt-clear writes still reload the counter.
- R9: With control bit 1 set, a counter expiry while raw status is already 1 raises `rst_req`. `rst_req` stays high until block reset.
- R10: Writing 0x1ACCE551 to the lock offset unlocks the block, and any other value locks it. While the block is locked, writes to load, control and interrupt clear have no effect. The lock offset reads 1 when locked and 0 when unlocked.
- R11: Each enabled tick lowers the count by exactly one, however many idle cycles separate the ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-rate strobe; one decrement per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| irq | output | 1 | Masked watchdog interrupt |
| rst_req | output | 1 | Sticky second-timeout reset request |

## Verification
A wrong counter value shows up at once on a read of the value offset, and it moves the cycle in which `irq` rises by the size of the error. A raw-status latch that sets or clears wrongly changes `irq` in the cycle after the offending tick or write. The same fault usually also moves the next `rst_req` by a whole reload period. A lock flag stuck in the wrong state shows up on the next protected write, because the written register reads back unchanged or changed when it should not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WDT_DW = 32;
    localparam int WDT_AW = 12;

    localparam logic [WDT_AW-1:0] OFS_LOAD  = 12'h000;
    localparam logic [WDT_AW-1:0] OFS_VALUE = 12'h004;
    localparam logic [WDT_AW-1:0] OFS_CTRL  = 12'h008;
    localparam logic [WDT_AW-1:0] OFS_CLR   = 12'h00C;
    localparam logic [WDT_AW-1:0] OFS_RAW   = 12'h010;
    localparam logic [WDT_AW-1:0] OFS_MSK   = 12'h014;
    localparam logic [WDT_AW-1:0] OFS_LOCK  = 12'hC00;

    localparam logic [WDT_DW-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef struct packed {
        logic rst_en;   // bit 1
        logic run;      // bit 0
    } wdt_ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_LOAD, SEL_VALUE, SEL_CTRL,
        SEL_CLR, SEL_RAW, SEL_MSK, SEL_LOCK
    } wdt_sel_e;

    function automatic wdt_sel_e wdt_decode(input logic [WDT_AW-1:0] a);
        case (a)
            OFS_LOAD:  return SEL_LOAD;
            OFS_VALUE: return SEL_VALUE;
            OFS_CTRL:  return SEL_CTRL;
            OFS_CLR:   return SEL_CLR;
            OFS_RAW:   return SEL_RAW;
            OFS_MSK:   return SEL_MSK;
            OFS_LOCK:  return SEL_LOCK;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DW = WDT_DW,
    parameter int AW = WDT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [DW-1:0] cnt_val,
    input  logic          raw_st,
    output logic [DW-1:0] prdata,
    output wdt_ctrl_t     ctrl,
    output logic [DW-1:0] load_q,
    output logic          ld_we,
    output logic          clr_we
);
    wdt_sel_e sel;
    logic     wr_acc;
    logic     ctrl_we;
    logic     lock_we;
    logic     locked_q;

    assign sel     = wdt_decode(paddr);
    assign wr_acc  = psel & penable & pwrite;
    assign ld_we   = wr_acc & (sel == SEL_LOAD) & ~locked_q;
    assign clr_we  = wr_acc & (sel == SEL_CLR)  & ~locked_q;
    assign ctrl_we = wr_acc & (sel == SEL_CTRL) & ~locked_q;
    assign lock_we = wr_acc & (sel == SEL_LOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= '1;
            ctrl     <= '0;
            locked_q <= 1'b0;
        end else begin
            if (ld_we)   load_q   <= pwdata;
            if (ctrl_we) ctrl     <= wdt_ctrl_t'(pwdata[1:0]);
            if (lock_we) locked_q <= (pwdata != UNLOCK_KEY);
        end
    end

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_LOAD:  prdata = load_q;
            SEL_VALUE: prdata = cnt_val;
            SEL_CTRL:  prdata[1:0] = ctrl;
            SEL_RAW:   prdata[0] = raw_st;
            SEL_MSK:   prdata[0] = raw_st & ctrl.run;
            SEL_LOCK:  prdata[0] = locked_q;
            default:   prdata = '0;
        endcase
    end

    // R10: protected registers hold while locked
    p_locked_load_r10: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr_acc && sel == SEL_LOAD) |=> $stable(load_q));
    p_locked_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr_acc && sel == SEL_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int DW = WDT_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  wdt_ctrl_t     ctrl,
    input  logic          ld_we,
    input  logic          clr_we,
    input  logic [DW-1:0] ld_val,
    input  logic [DW-1:0] load_q,
    output logic [DW-1:0] cnt_q,
    output logic          raw_q,
    output logic          rst_req_q
);
    logic          tick_go;
    logic          expire;
    logic [DW-1:0] nxt;

    assign tick_go = tick_en & ctrl.run;
    assign nxt     = (cnt_q == '0) ? load_q : cnt_q - 1'b1;
    assign expire  = tick_go & ~ld_we & ~clr_we & (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '1;
            raw_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (ld_we)        cnt_q <= ld_val;
            else if (clr_we)  cnt_q <= load_q;
            else if (tick_go) cnt_q <= nxt;

            if (clr_we)      raw_q <= 1'b0;
            else if (expire) raw_q <= 1'b1;

            if (expire && raw_q && ctrl.rst_en) rst_req_q <= 1'b1;
        end
    end

    // R3: a load write lands in the counter
    p_load_lands_r3: assert property (@(posedge clk) disable iff (rst)
        ld_we |=> cnt_q == $past(ld_val));
    // R8: no tick effect while stopped
    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !ld_we && !clr_we) |=> $stable(cnt_q));
    // R4: reaching zero sets raw status
    p_zero_sets_raw_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_go && !ld_we && !clr_we && cnt_q == 1) |=> (raw_q && cnt_q == 0));
    // R6: clear drops raw status
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> !raw_q);
    // R9: reset request is sticky
    p_rst_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> rst_req_q);
endmodule

// File: rtl/apb_tick_watchdog.sv
module apb_tick_watchdog
    import wdt_pkg::*;
#(
    parameter int DW = WDT_DW,
    parameter int AW = WDT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          irq,
    output logic          rst_req
);
    wdt_ctrl_t     ctrl;
    logic [DW-1:0] load_q;
    logic [DW-1:0] cnt_q;
    logic          ld_we;
    logic          clr_we;
    logic          raw_q;

    wdt_regs #(.DW(DW), .AW(AW)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .cnt_val (cnt_q),
        .raw_st  (raw_q),
        .prdata  (prdata),
        .ctrl    (ctrl),
        .load_q  (load_q),
        .ld_we   (ld_we),
        .clr_we  (clr_we)
    );

    wdt_counter #(.DW(DW)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .ctrl      (ctrl),
        .ld_we     (ld_we),
        .clr_we    (clr_we),
        .ld_val    (pwdata),
        .load_q    (load_q),
        .cnt_q     (cnt_q),
        .raw_q     (raw_q),
        .rst_req_q (rst_req)
    );

    assign pready = 1'b1;
    assign irq    = raw_q & ctrl.run;

    // R7: interrupt only when raw status is set
    p_irq_needs_raw_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> raw_q);
endmodule

// File: tb/apb_tick_watchdog_tb_top.sv
`timescale 1ns/1ps
module apb_tick_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model for the random phase
    logic [31:0] m_load, m_cnt;
    logic        m_raw;

    always #2 clk = ~clk;

    apb_tick_watchdog dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
        #0.5;
        d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    function automatic void model_tick();
        if (m_cnt == 0) m_cnt = m_load;
        else m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_raw = 1'b1;
    endfunction

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'd2024);
        do_reset();
        @(negedge clk);

        // R1 reset state
        expect_reg("R1 load", 12'h000, 32'hFFFF_FFFF);
        expect_reg("R1 value", 12'h004, 32'hFFFF_FFFF);
        expect_reg("R1 raw", 12'h010, 32'd0);
        expect_reg("R1 ctrl", 12'h008, 32'd0);
        expect_reg("R1 lock", 12'hC00, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rst_req", {31'd0, rst_req}, 32'd0);
        // R2 unmapped and ready
        expect_reg("R2 unmapped", 12'h018, 32'd0);
        expect_reg("R2 unmapped high", 12'h800, 32'd0);
        check("R2 pready", {31'd0, pready}, 32'd1);

        // R3/R4/R5/R6 main sequence
        wr(12'h008, 32'd1);
        wr(12'h000, 32'd1000);
        expect_reg("R3 loaded", 12'h004, 32'd1000);
        ticks(500, 0);
        expect_reg("R3 half", 12'h004, 32'd500);
        expect_reg("R3 raw low", 12'h010, 32'd0);
        ticks(499, 0);
        expect_reg("R3 one left", 12'h004, 32'd1);
        check("R4 irq before zero", {31'd0, irq}, 32'd0);
        ticks(1, 0);
        expect_reg("R4 value zero", 12'h004, 32'd0);
        expect_reg("R4 raw set", 12'h010, 32'd1);
        check("R7 irq", {31'd0, irq}, 32'd1);
        expect_reg("R7 masked", 12'h014, 32'd1);
        ticks(1, 0);
        expect_reg("R5 reload", 12'h004, 32'd1000);
        expect_reg("R5 raw held", 12'h010, 32'd1);
        ticks(500, 0);
        expect_reg("R5 half again", 12'h004, 32'd500);
        wr(12'h00C, 32'h0);
        expect_reg("R6 reload", 12'h004, 32'd1000);
        expect_reg("R6 raw clear", 12'h010, 32'd0);

        // R11 rate change keeps count
        ticks(100, 3);
        expect_reg("R11 slow ticks", 12'h004, 32'd900);
        ticks(100, 0);
        expect_reg("R11 fast ticks", 12'h004, 32'd800);

        // R8 stopped counter, R7 masking
        wr(12'h000, 32'd2);
        ticks(2, 0);
        wr(12'h008, 32'd0);
        expect_reg("R7 raw while stopped", 12'h010, 32'd1);
        expect_reg("R7 masked off", 12'h014, 32'd0);
        check("R7 irq off", {31'd0, irq}, 32'd0);
        wr(12'h000, 32'd40);
        ticks(10, 0);
        expect_reg("R8 hold", 12'h004, 32'd40);
        wr(12'h00C, 32'h5);
        expect_reg("R8 clear still works", 12'h010, 32'd0);
        expect_reg("R8 clear reload", 12'h004, 32'd40);

        // R9 reset request
        wr(12'h008, 32'd3);
        wr(12'h000, 32'd5);
        ticks(5, 0);
        check("R9 first timeout", {31'd0, rst_req}, 32'd0);
        ticks(5, 0);
        check("R9 before second", {31'd0, rst_req}, 32'd0);
        ticks(1, 0);
        check("R9 second timeout", {31'd0, rst_req}, 32'd1);
        wr(12'h00C, 32'd0);
        check("R9 sticky", {31'd0, rst_req}, 32'd1);
        do_reset();
        check("R9 cleared by reset", {31'd0, rst_req}, 32'd0);

        // R10 lock
        wr(12'h008, 32'd1);
        wr(12'h000, 32'd3);
        ticks(3, 0);
        wr(12'hC00, 32'h0);
        expect_reg("R10 locked reads 1", 12'hC00, 32'd1);
        wr(12'h000, 32'd77);
        expect_reg("R10 load ignored", 12'h000, 32'd3);
        expect_reg("R10 value ignored", 12'h004, 32'd0);
        wr(12'h008, 32'd0);
        expect_reg("R10 ctrl ignored", 12'h008, 32'd1);
        wr(12'h00C, 32'd0);
        expect_reg("R10 clear ignored", 12'h010, 32'd1);
        wr(12'hC00, 32'h1ACC_E551);
        expect_reg("R10 unlocked reads 0", 12'hC00, 32'd0);
        wr(12'h000, 32'd77);
        expect_reg("R10 load after unlock", 12'h004, 32'd77);
        wr(12'hC00, 32'h1ACC_E550);
        expect_reg("R10 near key locks", 12'hC00, 32'd1);
        wr(12'hC00, 32'h1ACC_E551);

        // random phase (R3 R4 R5 R6 R11)
        wr(12'h00C, 32'd0);
        m_load = 32'd77; m_cnt = 32'd77; m_raw = 1'b0;
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                int n, g;
                n = 1 + int'($urandom % 30);
                g = int'($urandom % 3);
                ticks(n, g);
                for (int k = 0; k < n; k++) model_tick();
            end else if (op == 1) begin
                logic [31:0] lv;
                lv = $urandom % 25;
                wr(12'h000, lv);
                m_load = lv; m_cnt = lv;
            end else begin
                wr(12'h00C, $urandom);
                m_cnt = m_load; m_raw = 1'b0;
            end
            rd(12'h004, v);
            check("R3 R5 random value", v, m_cnt);
            rd(12'h010, v);
            check("R4 R6 random raw", v, {31'd0, m_raw});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule